// File: doc/BRIEF.md
# Segment Display RAM Writer

This block holds the display memory of a multiplexed segment driver: 160 columns, one per segment line, each four bits wide, one bit per backplane row. A write pointer, loaded by command, selects the column where the next display byte lands. Each byte is split into bit groups whose size follows the multiplex mode, and each group goes into one column. The pointer then moves past every column that was filled.

A combinational read port serves the row scanner. In the static and 1:2 modes, two separate bank selections steer writes and reads to different rows. New frame data can then be assembled in one bank while the other bank is on the glass. In the 1:3 and 1:4 modes the banks play no part.

Mode encoding on `mode_i`: 0 = static, 1 = 1:2, 2 = 1:3, 3 = 1:4.

Top module: `lcd_seg_writer`

## Requirements
- R1: After reset every column reads as all zeros, the write pointer is column 0 and the row position is 0.
- R2: Static mode (mode 0): byte bit 7 is written to the pointer column, bit 6 to the next column, and so on down to bit 0 in the eighth column. All go to row `wbank_i`. The pointer advances by 8.
- R3: 1:2 mode (mode 1): each column takes two bits, the higher byte bit into row 2·`wbank_i[1]` and the lower into the row above it. Four columns are filled and the pointer advances by 4.
- R4: 1:3 mode (mode 2): bits are stored from bit 7 downward into rows 0, 1, 2 of a column, then rows 0, 1, 2 of the next. The pointer advances only when row 2 of a column is written. The row position left over after a byte carries into the next byte.
- R5: 1:4 mode (mode 3): bits 7..4 go to rows 0..3 of the pointer column and bits 3..0 to rows 0..3 of the next column. The pointer advances by 2.
- R6: A pointer load sets the pointer to `ptr_val_i`, or to 0 when that value is 160 or more, and clears the row position. When a byte arrives in the same cycle, that byte is stored starting at the loaded column.
- R7: The pointer wraps from column 159 to column 0, including in the middle of a byte.
- R8: In static mode `rd_rows_o[0]` shows row `rbank_i` of the addressed column, and bits 3..1 read 0.
- R9: In 1:2 mode `rd_rows_o[1:0]` shows rows 2·`rbank_i[1]` and 2·`rbank_i[1]`+1, and bits 3..2 read 0.
- R10: In 1:3 and 1:4 modes both bank selections are ignored. The read shows rows 0..2 (bit 3 reads 0) or rows 0..3 respectively.
- R11: A byte write changes only the column bits it targets. Other rows of the same column and all other columns keep their contents.
- R12: A read of a column number 160 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Multiplex mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| wbank_i | input | 2 | Bank used by writes (row in static, bit 1 picks row pair in 1:2) |
| rbank_i | input | 2 | Bank shown on the read port |
| ptr_load_i | input | 1 | Load the write pointer from `ptr_val_i` |
| ptr_val_i | input | 8 | Column to load into the pointer |
| byte_vld_i | input | 1 | Display byte strobe |
| byte_i | input | 8 | Display byte |
| rd_col_i | input | 8 | Column addressed by the row scanner |
| rd_rows_o | output | 4 | Displayed rows of the addressed column, bit n = row n |

## Verification
The assertions assume that the mode changes only in a cycle that also loads the pointer. The row position left over from a 1:3 byte then never meets a mode with a different group size. The random stimulus follows this rule: whenever it draws a mode other than the last write mode, it forces a pointer load in that cycle. It also adds loads at random, with values drawn over the full 8-bit range. Directed cases cover the pointer wrap, a load together with a byte, a leftover row position after a 1:3 byte, and reads past the last column.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  localparam int unsigned ROWS   = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MUX_STATIC  = 2'd0,
    MUX_DUPLEX  = 2'd1,
    MUX_TRIPLEX = 2'd2,
    MUX_QUAD    = 2'd3
  } mux_mode_e;

  // rows occupied by one column in a mode
  function automatic logic [2:0] rows_used(mux_mode_e m);
    case (m)
      MUX_STATIC:  return 3'd1;
      MUX_DUPLEX:  return 3'd2;
      MUX_TRIPLEX: return 3'd3;
      default:     return 3'd4;
    endcase
  endfunction

  // first row a write or read lands on for a given bank
  function automatic logic [1:0] row_base(mux_mode_e m, logic [1:0] bank);
    case (m)
      MUX_STATIC: return bank;
      MUX_DUPLEX: return {bank[1], 1'b0};
      default:    return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/lcd_seg_addr_gen.sv
module lcd_seg_addr_gen
  import lcd_seg_pkg::*;
#(
  parameter int COLS = 160,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  mux_mode_e                     mode_i,
  input  logic [1:0]                    bank_i,
  input  logic                          load_i,
  input  logic [COL_W-1:0]              load_col_i,
  input  logic                          byte_vld_i,
  output logic [BYTE_W-1:0][COL_W-1:0]  tgt_col_o,
  output logic [BYTE_W-1:0][1:0]        tgt_row_o,
  output logic [COL_W-1:0]              ptr_o,
  output logic [1:0]                    sub_o
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [COL_W-1:0] ptr_q, ptr_d;
  logic [1:0]       sub_q, sub_d;
  logic             ptr_en;

  always_comb begin
    logic [2:0]       n;
    logic [1:0]       base;
    logic [COL_W-1:0] c;
    logic [2:0]       s;
    logic [COL_W-1:0] c_start;
    logic [2:0]       s_start;

    n    = rows_used(mode_i);
    base = row_base(mode_i, bank_i);

    if (load_i) begin
      c_start = (int'(load_col_i) < COLS) ? load_col_i : '0;
      s_start = 3'd0;
    end else begin
      c_start = ptr_q;
      s_start = ({1'b0, sub_q} < n) ? {1'b0, sub_q} : 3'd0;
    end

    c = c_start;
    s = s_start;
    for (int k = BYTE_W - 1; k >= 0; k--) begin
      tgt_col_o[k] = c;
      tgt_row_o[k] = base + s[1:0];
      s = s + 3'd1;
      if (s == n) begin
        s = 3'd0;
        c = (c == LAST_COL) ? '0 : c + COL_W'(1);
      end
    end

    ptr_en = load_i | byte_vld_i;
    if (byte_vld_i) begin
      ptr_d = c;
      sub_d = s[1:0];
    end else begin
      ptr_d = c_start;
      sub_d = s_start[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      sub_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
      sub_q <= sub_d;
    end
  end

  assign ptr_o = ptr_q;
  assign sub_o = sub_q;

endmodule

// File: rtl/lcd_seg_store.sv
module lcd_seg_store
  import lcd_seg_pkg::*;
#(
  parameter int COLS = 160,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [BYTE_W-1:0]             data_i,
  input  logic [BYTE_W-1:0][COL_W-1:0]  tgt_col_i,
  input  logic [BYTE_W-1:0][1:0]        tgt_row_i,
  input  logic [COL_W-1:0]              rd_col_i,
  output logic [ROWS-1:0]               rd_nib_o
);

  logic [COLS*ROWS-1:0] mem_flat;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] cell_q, cell_d;
    logic            cell_en;

    always_comb begin
      cell_d  = cell_q;
      cell_en = 1'b0;
      for (int k = 0; k < BYTE_W; k++) begin
        if (wr_en_i && tgt_col_i[k] == COL_W'(c)) begin
          cell_en             = 1'b1;
          cell_d[tgt_row_i[k]] = data_i[k];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_en) cell_q <= cell_d;
    end

    assign mem_flat[c*ROWS +: ROWS] = cell_q;
  end

  always_comb begin
    rd_nib_o = '0;
    for (int c = 0; c < COLS; c++) begin
      if (rd_col_i == COL_W'(c)) rd_nib_o = mem_flat[c*ROWS +: ROWS];
    end
  end

endmodule

// File: rtl/lcd_seg_view.sv
module lcd_seg_view
  import lcd_seg_pkg::*;
(
  input  mux_mode_e        mode_i,
  input  logic [1:0]       bank_i,
  input  logic [ROWS-1:0]  nib_i,
  output logic [ROWS-1:0]  rows_o
);

  logic [1:0] base;

  always_comb begin
    base   = row_base(mode_i, bank_i);
    rows_o = '0;
    case (mode_i)
      MUX_STATIC:  rows_o[0]   = nib_i[base];
      MUX_DUPLEX:  rows_o[1:0] = base[1] ? nib_i[3:2] : nib_i[1:0];
      MUX_TRIPLEX: rows_o[2:0] = nib_i[2:0];
      default:     rows_o      = nib_i;
    endcase
  end

endmodule

// File: rtl/lcd_seg_writer.sv
module lcd_seg_writer
  import lcd_seg_pkg::*;
#(
  parameter int COLS = 160,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        wbank_i,
  input  logic [1:0]        rbank_i,
  input  logic              ptr_load_i,
  input  logic [COL_W-1:0]  ptr_val_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [3:0]        rd_rows_o
);

  mux_mode_e                     mode;
  logic [BYTE_W-1:0][COL_W-1:0]  tgt_col;
  logic [BYTE_W-1:0][1:0]        tgt_row;
  logic [COL_W-1:0]              cur_ptr;
  logic [1:0]                    cur_sub;
  logic [ROWS-1:0]               rd_nib;

  assign mode = mux_mode_e'(mode_i);

  lcd_seg_addr_gen #(.COLS(COLS)) i_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .bank_i     (wbank_i),
    .load_i     (ptr_load_i),
    .load_col_i (ptr_val_i),
    .byte_vld_i (byte_vld_i),
    .tgt_col_o  (tgt_col),
    .tgt_row_o  (tgt_row),
    .ptr_o      (cur_ptr),
    .sub_o      (cur_sub)
  );

  lcd_seg_store #(.COLS(COLS)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (byte_vld_i),
    .data_i    (byte_i),
    .tgt_col_i (tgt_col),
    .tgt_row_i (tgt_row),
    .rd_col_i  (rd_col_i),
    .rd_nib_o  (rd_nib)
  );

  lcd_seg_view i_view (
    .mode_i (mode),
    .bank_i (rbank_i),
    .nib_i  (rd_nib),
    .rows_o (rd_rows_o)
  );

endmodule

// File: rtl/lcd_seg_writer_chk.sv
module lcd_seg_writer_chk #(
  parameter int COLS = 160,
  localparam int COL_W = $clog2(COLS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              ptr_load_i,
  input logic [COL_W-1:0]  ptr_val_i,
  input logic              byte_vld_i,
  input logic [3:0]        rd_rows_o,
  input logic [COL_W-1:0]  cur_ptr,
  input logic [1:0]        cur_sub
);

  function automatic logic [COL_W-1:0] adv(logic [COL_W-1:0] p, int s);
    return COL_W'((int'(p) + s) % COLS);
  endfunction

  // R7
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_ptr) < COLS);

  // R4
  sub_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_sub <= 2'd2);

  // R2
  static_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !ptr_load_i && mode_i == 2'd0)
    |=> cur_ptr == adv($past(cur_ptr), 8));

  // R5
  quad_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !ptr_load_i && mode_i == 2'd3 && cur_sub == 2'd0)
    |=> cur_ptr == adv($past(cur_ptr), 2));

  // R6
  load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load_i && !byte_vld_i)
    |=> (cur_sub == 2'd0) &&
        (cur_ptr == ((int'($past(ptr_val_i)) < COLS) ? $past(ptr_val_i) : '0)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_load_i && !byte_vld_i) |=> $stable(cur_ptr) && $stable(cur_sub));

  // R8
  static_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0) |-> rd_rows_o[3:1] == 3'd0);

  // R10
  triplex_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |-> rd_rows_o[3] == 1'b0);

endmodule

bind lcd_seg_writer lcd_seg_writer_chk #(.COLS(COLS)) i_lcd_seg_writer_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .ptr_load_i (ptr_load_i),
  .ptr_val_i  (ptr_val_i),
  .byte_vld_i (byte_vld_i),
  .rd_rows_o  (rd_rows_o),
  .cur_ptr    (cur_ptr),
  .cur_sub    (cur_sub)
);

// File: tb/test_lcd_seg_writer.sv
module test_lcd_seg_writer;

  localparam int NCOL = 160;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i, wbank_i, rbank_i;
  logic       ptr_load_i, byte_vld_i;
  logic [7:0] ptr_val_i, byte_i, rd_col_i;
  logic [3:0] rd_rows_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit [3:0] mdl [NCOL];
  int mptr, msub;

  always #2 clk = ~clk;

  lcd_seg_writer #(.COLS(NCOL)) i_lcd_seg_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .wbank_i    (wbank_i),
    .rbank_i    (rbank_i),
    .ptr_load_i (ptr_load_i),
    .ptr_val_i  (ptr_val_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .rd_col_i   (rd_col_i),
    .rd_rows_o  (rd_rows_o)
  );

  function automatic int rows_of(logic [1:0] m);
    return int'(m) + 1;
  endfunction

  function automatic int base_of(logic [1:0] m, logic [1:0] b);
    if (m == 2'd0) return int'(b);
    if (m == 2'd1) return b[1] ? 2 : 0;
    return 0;
  endfunction

  function automatic void mdl_write(logic [1:0] m, logic [1:0] b, logic [7:0] d,
                                    bit ld, int lv, bit wr);
    int n = rows_of(m);
    int base = base_of(m, b);
    if (ld) begin
      mptr = (lv < NCOL) ? lv : 0;
      msub = 0;
    end else if (msub >= n) msub = 0;
    if (wr) begin
      for (int k = 7; k >= 0; k--) begin
        mdl[mptr][base + msub] = d[k];
        msub++;
        if (msub == n) begin
          msub = 0;
          mptr = (mptr + 1) % NCOL;
        end
      end
    end
  endfunction

  function automatic logic [3:0] exp_view(int col, logic [1:0] m, logic [1:0] rb);
    logic [3:0] nib;
    logic [3:0] r = 4'd0;
    if (col >= NCOL) return 4'd0;
    nib = mdl[col];
    case (m)
      2'd0: r[0] = nib[rb];
      2'd1: r[1:0] = rb[1] ? nib[3:2] : nib[1:0];
      2'd2: r[2:0] = nib[2:0];
      default: r = nib;
    endcase
    return r;
  endfunction

  task automatic send(logic [1:0] m, logic [1:0] b, logic [7:0] d,
                      bit ld, int lv, bit wr);
    @(negedge clk);
    mode_i     = m;
    wbank_i    = b;
    byte_i     = d;
    byte_vld_i = wr;
    ptr_load_i = ld;
    ptr_val_i  = 8'(lv);
    @(posedge clk);
    mdl_write(m, b, d, ld, lv, wr);
    #1;
    byte_vld_i = 1'b0;
    ptr_load_i = 1'b0;
  endtask

  task automatic cmp(string req, int col, logic [1:0] m, logic [1:0] rb,
                     logic [3:0] exp);
    @(negedge clk);
    rd_col_i = 8'(col);
    mode_i   = m;
    rbank_i  = rb;
    #1;
    n_chk++;
    if (rd_rows_o !== exp) begin
      n_fail++;
      $display("FAIL %s col %0d mode %0d bank %0d: got %b expected %b",
               req, col, m, rb, rd_rows_o, exp);
    end
  endtask

  task automatic chk_col(string req, int col, logic [1:0] m, logic [1:0] rb);
    cmp(req, col, m, rb, exp_view(col, m, rb));
  endtask

  task automatic chk_all(string req, logic [1:0] m, logic [1:0] rb);
    for (int c = 0; c < NCOL; c++) chk_col(req, c, m, rb);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] cur_mode;
    void'($urandom(32'd20250517));
    for (int c = 0; c < NCOL; c++) mdl[c] = 4'd0;
    mptr = 0; msub = 0;
    rst_n = 1'b0;
    mode_i = 2'd3; wbank_i = 2'd0; rbank_i = 2'd0;
    ptr_load_i = 1'b0; byte_vld_i = 1'b0;
    ptr_val_i = 8'd0; byte_i = 8'd0; rd_col_i = 8'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset contents and first write at column 0
    chk_all("R1", 2'd3, 2'd0);
    send(2'd3, 2'd0, 8'hC3, 1'b0, 0, 1'b1);
    cmp("R1", 0, 2'd3, 2'd0, 4'b0011);
    cmp("R1", 1, 2'd3, 2'd0, 4'b1100);

    // R12 out-of-range read
    cmp("R12", 200, 2'd3, 2'd0, 4'd0);
    cmp("R12", 160, 2'd3, 2'd0, 4'd0);

    // R5 quad, load with byte in the same cycle (R6)
    send(2'd3, 2'd0, 8'hA5, 1'b1, 10, 1'b1);
    cmp("R5", 10, 2'd3, 2'd0, 4'b0101);
    cmp("R6", 11, 2'd3, 2'd0, 4'b1010);

    // R11 static write touches one row only
    send(2'd3, 2'd0, 8'hFF, 1'b1, 20, 1'b1);
    send(2'd0, 2'd2, 8'h00, 1'b1, 20, 1'b1);
    cmp("R11", 20, 2'd3, 2'd0, 4'b1011);
    cmp("R11", 21, 2'd3, 2'd0, 4'b1011);
    cmp("R11", 22, 2'd3, 2'd0, 4'b0000);

    // R2 static: bit 7 first, pointer +8
    send(2'd0, 2'd1, 8'h81, 1'b1, 30, 1'b1);
    cmp("R2", 30, 2'd0, 2'd1, 4'b0001);
    cmp("R2", 31, 2'd0, 2'd1, 4'b0000);
    cmp("R2", 37, 2'd0, 2'd1, 4'b0001);
    send(2'd0, 2'd1, 8'h80, 1'b0, 0, 1'b1);
    cmp("R2", 38, 2'd0, 2'd1, 4'b0001);
    // R8 other bank of same column is empty
    cmp("R8", 30, 2'd0, 2'd0, 4'b0000);

    // R3 duplex upper pair, R9 view
    send(2'd1, 2'd2, 8'hE4, 1'b1, 50, 1'b1);
    cmp("R3", 50, 2'd1, 2'd2, 4'b0011);
    cmp("R3", 51, 2'd1, 2'd2, 4'b0001);
    cmp("R3", 52, 2'd1, 2'd2, 4'b0010);
    cmp("R9", 51, 2'd1, 2'd0, 4'b0000);
    cmp("R9", 51, 2'd3, 2'd0, 4'b0100);

    // R4 triplex carry of leftover row
    send(2'd2, 2'd0, 8'hFF, 1'b1, 60, 1'b1);
    send(2'd2, 2'd0, 8'h00, 1'b0, 0, 1'b1);
    cmp("R4", 60, 2'd2, 2'd0, 4'b0111);
    cmp("R4", 62, 2'd2, 2'd0, 4'b0011);
    cmp("R4", 63, 2'd2, 2'd0, 4'b0000);
    send(2'd2, 2'd0, 8'hFF, 1'b0, 0, 1'b1);
    chk_col("R4", 65, 2'd2, 2'd0);
    chk_col("R4", 66, 2'd2, 2'd0);

    // R10 bank ignored in quad and triplex
    send(2'd3, 2'd3, 8'h96, 1'b1, 70, 1'b1);
    cmp("R10", 70, 2'd3, 2'd1, 4'b1001);
    cmp("R10", 71, 2'd3, 2'd2, 4'b0110);
    cmp("R10", 71, 2'd2, 2'd3, 4'b0110);

    // R7 wrap, R6 load of out-of-range value
    send(2'd3, 2'd0, 8'hFF, 1'b1, 158, 1'b1);
    send(2'd3, 2'd0, 8'hFF, 1'b0, 0, 1'b1);
    cmp("R7", 159, 2'd3, 2'd0, 4'hF);
    cmp("R7", 0, 2'd3, 2'd0, 4'hF);
    cmp("R7", 1, 2'd3, 2'd0, 4'hF);
    send(2'd0, 2'd0, 8'hFF, 1'b1, 156, 1'b1);
    chk_col("R7", 3, 2'd0, 2'd0);
    send(2'd3, 2'd0, 8'h00, 1'b1, 231, 1'b0);
    send(2'd3, 2'd0, 8'h0F, 1'b0, 0, 1'b1);
    cmp("R6", 0, 2'd3, 2'd0, 4'h0);
    cmp("R6", 1, 2'd3, 2'd0, 4'hF);

    // random traffic; mode change always with a load
    cur_mode = 2'd3;
    for (int it = 0; it < 600; it++) begin
      logic [1:0] m = 2'($urandom % 4);
      bit ld = (m != cur_mode) || (($urandom % 8) == 0);
      int lv = int'($urandom % 256);
      bit wr = (($urandom % 6) != 0);
      send(m, 2'($urandom % 4), 8'($urandom), ld, lv, wr);
      cur_mode = m;
      if (it % 100 == 99) begin
        logic [1:0] vm = 2'($urandom % 4);
        chk_all((vm == 2'd0) ? "R8" : (vm == 2'd1) ? "R9" : "R10",
                vm, 2'($urandom % 4));
      end
    end
    chk_all("R11", 2'd3, 2'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule